// File: doc/BRIEF.md
# I2C Slave Serial Port

This block is the target side of a two-wire serial bus, with a small register file facing a host core. SCL and SDA arrive from open-drain pads and pass through a synchronizer running on the system clock. The block detects START and STOP conditions, follows each transfer bit by bit, and pulls SDA low when it acknowledges a byte or sends a zero bit. It never drives SCL.

The host sets the device address, selects 7-bit or 10-bit addressing and enables general-call recognition. Received bytes are shifted in MSB first and then copied into a buffer register, so the shifter can accept the next byte while the host reads the previous one. The transmit path is write-through: a host write to the buffer loads the buffer and the shifter together. On a read-address match the pending buffer byte is copied back into the shifter, because the shifter was just used for the address. A status register reports START, STOP, address match, transfer direction, buffer state and overflow, and a level interrupt follows its flag bit.

Host register offsets are 0 buffer, 1 address low byte, 2 control and 3 status. Control bit 0 selects 10-bit mode, bit 1 enables general call, bits 3:2 hold address bits 9:8, and bit 4 lets START and STOP raise the interrupt. Status bits are 0 buffer full, 1 read direction, 2 last event was data (0 = address), 3 START seen, 4 STOP seen, 5 last match was general call, 6 overflow and 7 interrupt flag. Reading status is free of side effects, and reading the buffer clears buffer full.

Top module: `i2c_slave_port`

## Requirements
- R1: A START (SDA falls while SCL is high) sets status bit 3 and clears bit 4. A STOP (SDA rises while SCL is high) sets bit 4, clears bit 3 and releases SDA. With control bit 4 set, either event also sets the interrupt flag (status bit 7).
- R2: In 7-bit mode, a first byte whose bits 7:1 equal address register bits 6:0 is acknowledged by pulling SDA low on the ninth clock. `addr_match` pulses for one cycle, status bit 7 is set, status bit 2 is cleared and status bit 1 takes the byte's bit 0.
- R3: A first byte that matches nothing is not acknowledged, and the block neither acknowledges nor drives SDA again until the next START.
- R4: In 10-bit mode, a first byte of 11110, then control bits 3:2, then 0 is acknowledged without a match pulse. A following byte equal to the address low byte is acknowledged with a match pulse, and any other second byte is not acknowledged. After such a full match, a repeated START with a first byte of 11110, control bits 3:2 and then 1 is a read match. Without a full match since the last STOP, that first byte is not acknowledged.
- R5: Address byte 0x00 is a general call. It is acknowledged as a write match, with status bit 5 set, only while control bit 1 is set. Otherwise it is not acknowledged.
- R6: In a write transfer, each data byte is sampled MSB first on SCL rising edges and then copied into the buffer. The block sets status bits 0, 2 and 7 and acknowledges the byte.
- R7: A data byte that completes while status bit 0 is set is discarded. The buffer keeps the old byte, status bit 6 is set and the byte is not acknowledged.
- R8: In a read transfer, the buffer byte is driven on SDA MSB first, with each bit changed only after an SCL falling edge. At the end of the byte SDA is released, status bit 0 is cleared and bit 7 is set. A master NACK stops all further driving until the next START.
- R9: Host writes to the status register change only bits 7 and 6. Bits 5:0 keep their values.
- R10: A host read of the buffer returns the stored byte and clears status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| sda_pull_low | output | 1 | 1 enables the open-drain SDA pull-down |
| host_addr | input | 2 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects only) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Interrupt, equal to status bit 7 |
| addr_match | output | 1 | One-cycle pulse on an address match |

## Verification
The bound checker watches rules that must hold on every cycle: SDA changes only after an SCL fall, a START or a STOP; a match pulse lasts one cycle and comes with the acknowledge; an overflow never acknowledges; a stored byte shows up as buffer full and interrupt; and the START and STOP bits are never set together. Only the bench scenarios can show that the right addresses match in both modes, including the two-byte 10-bit sequence, the repeated START needed for a 10-bit read and the general-call enable. The same holds for the byte values that reach the buffer or the wire, for the ignored status writes, and for the silence that follows a NACK.

// File: rtl/i2csp_pkg.sv
package i2csp_pkg;

  localparam int BYTE_W = 8;
  localparam int OWN_ADDR_W = 10;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  localparam logic [1:0] REG_BUF  = 2'd0;
  localparam logic [1:0] REG_ADDR = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;
  localparam logic [BYTE_W-1:0] GCALL_BYTE = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR10,
    ST_RXDATA,
    ST_TXDATA,
    ST_WAIT
  } eng_state_t;

  function automatic logic hit7(input logic [BYTE_W-1:0] b, input logic [6:0] own);
    return b[7:1] == own;
  endfunction

  function automatic logic hit10_hi(input logic [BYTE_W-1:0] b, input logic [1:0] hi);
    return (b[7:3] == TEN_BIT_TAG) && (b[2:1] == hi);
  endfunction

  function automatic logic hit_gcall(input logic [BYTE_W-1:0] b, input logic enable);
    return enable && (b == GCALL_BYTE);
  endfunction

endpackage

// File: rtl/i2csp_line_mon.sv
module i2csp_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_prev;
  logic sda_prev;
  logic scl_now;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[TOP-1:0], scl_in};
          sda_pipe <= {sda_pipe[TOP-1:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_pipe[TOP];
      sda_prev <= sda_pipe[TOP];
    end
  end

  assign scl_now   = scl_pipe[TOP];
  assign sda_lvl   = sda_pipe[TOP];
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_evt = scl_now & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2csp_engine.sv
module i2csp_engine
  import i2csp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_lvl,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic [OWN_ADDR_W-1:0] own_addr,
  input  logic                  ten_bit,
  input  logic                  gc_en,
  input  logic                  buf_full,
  input  logic [BYTE_W-1:0]     buf_q,
  input  logic                  host_load,
  input  logic [BYTE_W-1:0]     host_wdata,
  output logic                  sda_oe,
  output logic                  rx_store,
  output logic [BYTE_W-1:0]     rx_byte,
  output logic                  ovf_evt,
  output logic                  match_evt,
  output logic                  match_rw,
  output logic                  match_gc,
  output logic                  tx_done
);

  eng_state_t           state;
  logic [BYTE_W-1:0]    shreg;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 ack_phase;
  logic                 master_nack;
  logic                 hi10_ok;

  logic                 byte_done;
  logic                 is_gc;
  logic                 hit_7;
  logic                 hit_hi;
  logic                 hit_lo;

  assign byte_done = scl_fall && !ack_phase && (bit_cnt == CNT_W'(BYTE_W));
  assign is_gc     = hit_gcall(shreg, gc_en);
  assign hit_7     = hit7(shreg, own_addr[6:0]);
  assign hit_hi    = hit10_hi(shreg, own_addr[9:8]);
  assign hit_lo    = shreg == own_addr[7:0];
  assign rx_byte   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      shreg       <= '0;
      bit_cnt     <= '0;
      ack_phase   <= 1'b0;
      master_nack <= 1'b0;
      hi10_ok     <= 1'b0;
      sda_oe      <= 1'b0;
      rx_store    <= 1'b0;
      ovf_evt     <= 1'b0;
      match_evt   <= 1'b0;
      match_rw    <= 1'b0;
      match_gc    <= 1'b0;
      tx_done     <= 1'b0;
    end else begin
      rx_store  <= 1'b0;
      ovf_evt   <= 1'b0;
      match_evt <= 1'b0;
      tx_done   <= 1'b0;
      if (stop_evt) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        ack_phase <= 1'b0;
        bit_cnt   <= '0;
        hi10_ok   <= 1'b0;
      end else if (start_evt) begin
        state     <= ST_ADDR;
        sda_oe    <= 1'b0;
        ack_phase <= 1'b0;
        bit_cnt   <= '0;
      end else if (state == ST_IDLE || state == ST_WAIT) begin
        if (host_load) shreg <= host_wdata;
      end else if (scl_rise) begin
        if (!ack_phase) begin
          if (state == ST_TXDATA) shreg <= {shreg[BYTE_W-2:0], 1'b0};
          else                    shreg <= {shreg[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (state == ST_TXDATA) begin
          master_nack <= sda_lvl;
        end
      end else if (scl_fall && ack_phase) begin
        ack_phase <= 1'b0;
        bit_cnt   <= '0;
        if (state == ST_TXDATA && master_nack) begin
          state  <= ST_WAIT;
          sda_oe <= 1'b0;
        end else if (state == ST_TXDATA) begin
          sda_oe <= ~shreg[BYTE_W-1];
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (byte_done) begin
        ack_phase <= 1'b1;
        unique case (state)
          ST_ADDR: begin
            if (is_gc) begin
              sda_oe <= 1'b1; match_evt <= 1'b1; match_rw <= 1'b0; match_gc <= 1'b1;
              state  <= ST_RXDATA;
            end else if (!ten_bit && hit_7) begin
              sda_oe <= 1'b1; match_evt <= 1'b1; match_rw <= shreg[0]; match_gc <= 1'b0;
              if (shreg[0]) begin
                state <= ST_TXDATA; shreg <= buf_q; master_nack <= 1'b0;
              end else begin
                state <= ST_RXDATA;
              end
            end else if (ten_bit && hit_hi && !shreg[0]) begin
              sda_oe <= 1'b1;
              state  <= ST_ADDR10;
            end else if (ten_bit && hit_hi && hi10_ok) begin
              sda_oe <= 1'b1; match_evt <= 1'b1; match_rw <= 1'b1; match_gc <= 1'b0;
              state  <= ST_TXDATA; shreg <= buf_q; master_nack <= 1'b0;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_ADDR10: begin
            if (hit_lo) begin
              sda_oe <= 1'b1; match_evt <= 1'b1; match_rw <= 1'b0; match_gc <= 1'b0;
              hi10_ok <= 1'b1;
              state  <= ST_RXDATA;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_RXDATA: begin
            if (buf_full) ovf_evt <= 1'b1;
            else begin
              rx_store <= 1'b1;
              sda_oe   <= 1'b1;
            end
          end
          ST_TXDATA: begin
            sda_oe  <= 1'b0;
            tx_done <= 1'b1;
          end
          default: state <= ST_WAIT;
        endcase
      end else if (scl_fall && state == ST_TXDATA) begin
        sda_oe <= ~shreg[BYTE_W-1];
      end else if (host_load) begin
        shreg <= host_wdata;
      end
    end
  end

endmodule

// File: rtl/i2csp_regs.sv
module i2csp_regs
  import i2csp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [BYTE_W-1:0]     host_wdata,
  output logic [BYTE_W-1:0]     host_rdata,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic                  rx_store,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  ovf_evt,
  input  logic                  match_evt,
  input  logic                  match_rw,
  input  logic                  match_gc,
  input  logic                  tx_done,
  output logic [OWN_ADDR_W-1:0] own_addr,
  output logic                  ten_bit,
  output logic                  gc_en,
  output logic                  buf_full,
  output logic [BYTE_W-1:0]     buf_q,
  output logic                  host_load,
  output logic [BYTE_W-1:0]     stat_vec,
  output logic                  irq
);

  logic [BYTE_W-1:0] addr_lo;
  logic [4:0]        ctrl;
  logic              st_rw, st_data, st_start, st_stop, st_gc, st_ovf, st_irq;
  logic              wr_stat, wr_buf, rd_buf;
  logic              irq_set;

  assign wr_stat   = host_wr && host_addr == REG_STAT;
  assign wr_buf    = host_wr && host_addr == REG_BUF;
  assign rd_buf    = host_rd && host_addr == REG_BUF;
  assign host_load = wr_buf;
  assign irq_set   = match_evt || rx_store || tx_done || (ctrl[4] && (start_evt || stop_evt));

  assign ten_bit  = ctrl[0];
  assign gc_en    = ctrl[1];
  assign own_addr = {ctrl[3:2], addr_lo};
  assign stat_vec = {st_irq, st_ovf, st_gc, st_stop, st_start, st_data, st_rw, buf_full};
  assign irq      = st_irq;

  always_comb begin
    unique case (host_addr)
      REG_BUF:  host_rdata = buf_q;
      REG_ADDR: host_rdata = addr_lo;
      REG_CTRL: host_rdata = {3'b000, ctrl};
      default:  host_rdata = stat_vec;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= '0;
      ctrl    <= '0;
    end else if (host_wr) begin
      if (host_addr == REG_ADDR) addr_lo <= host_wdata;
      if (host_addr == REG_CTRL) ctrl    <= host_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else begin
      if (rx_store)    buf_q <= rx_byte;
      else if (wr_buf) buf_q <= host_wdata;
      if (rx_store)     buf_full <= 1'b1;
      else if (tx_done) buf_full <= 1'b0;
      else if (wr_buf)  buf_full <= 1'b1;
      else if (rd_buf)  buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rw <= 1'b0; st_data <= 1'b0; st_start <= 1'b0; st_stop <= 1'b0;
      st_gc <= 1'b0; st_ovf <= 1'b0; st_irq <= 1'b0;
    end else begin
      if (start_evt) begin
        st_start <= 1'b1; st_stop <= 1'b0;
      end else if (stop_evt) begin
        st_start <= 1'b0; st_stop <= 1'b1;
      end
      if (match_evt) begin
        st_rw <= match_rw; st_data <= 1'b0; st_gc <= match_gc;
      end else if (rx_store) begin
        st_data <= 1'b1;
      end
      if (ovf_evt)      st_ovf <= 1'b1;
      else if (wr_stat) st_ovf <= host_wdata[6];
      if (irq_set)      st_irq <= 1'b1;
      else if (wr_stat) st_irq <= host_wdata[7];
    end
  end

endmodule

// File: rtl/i2c_slave_port.sv
module i2c_slave_port
  import i2csp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              irq,
  output logic              addr_match
);

  logic                  sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic [OWN_ADDR_W-1:0] own_addr;
  logic                  ten_bit, gc_en, buf_full, host_load;
  logic [BYTE_W-1:0]     buf_q, rx_byte, stat_vec;
  logic                  sda_oe, rx_store, ovf_evt, match_evt, match_rw, match_gc, tx_done;

  i2csp_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2csp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .ten_bit(ten_bit), .gc_en(gc_en),
    .buf_full(buf_full), .buf_q(buf_q), .host_load(host_load),
    .host_wdata(host_wdata), .sda_oe(sda_oe), .rx_store(rx_store),
    .rx_byte(rx_byte), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .match_rw(match_rw), .match_gc(match_gc), .tx_done(tx_done)
  );

  i2csp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .start_evt(start_evt), .stop_evt(stop_evt), .rx_store(rx_store),
    .rx_byte(rx_byte), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .match_rw(match_rw), .match_gc(match_gc), .tx_done(tx_done),
    .own_addr(own_addr), .ten_bit(ten_bit), .gc_en(gc_en),
    .buf_full(buf_full), .buf_q(buf_q), .host_load(host_load),
    .stat_vec(stat_vec), .irq(irq)
  );

  assign sda_pull_low = sda_oe;
  assign addr_match   = match_evt;

endmodule

// File: rtl/i2csp_checker.sv
module i2csp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_pull_low,
  input logic       addr_match,
  input logic       ovf_evt,
  input logic       rx_store,
  input logic [7:0] stat_vec
);

  p_sda_edge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_pull_low));

  p_match_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !addr_match);

  p_match_acks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> sda_pull_low);

  p_no_ovf_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !sda_pull_low);

  p_ovf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat_vec[6]);

  p_rx_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store |=> (stat_vec[0] && stat_vec[7]));

  p_start_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (stat_vec[3] && !stat_vec[4]));

  p_stop_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (stat_vec[4] && !stat_vec[3] && !sda_pull_low));

  p_sp_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_vec[4:3]));

endmodule

bind i2c_slave_port i2csp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_pull_low(sda_pull_low), .addr_match(addr_match),
  .ovf_evt(ovf_evt), .rx_store(rx_store), .stat_vec(stat_vec)
);

// File: tb/test_i2c_slave_port.sv
module test_i2c_slave_port;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_pull_low;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;
  logic       addr_match;

  int checks = 0;
  int fails = 0;
  int match_cnt = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  always_comb sda_line = sda_m & ~sda_pull_low;

  i2c_slave_port i_i2c_slave_port (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .addr_match(addr_match)
  );

  always @(posedge clk) if (rst_n && addr_match) match_cnt <= match_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1'b1; wq(Q); b = {b[6:0], sda_line}; wq(Q); scl_m = 1'b0;
    end
    sda_m = ~m_ack; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  // scoreboard driver: sends a data byte and queues it when it must be stored
  task automatic drive_data(input logic [7:0] b, input logic stored, output logic ack);
    send_byte(b, ack);
    if (stored) exp_q.push_back(b);
  endtask

  // scoreboard monitor: pops the oldest expected byte and compares the buffer read
  task automatic drain(input string req);
    logic [7:0] got;
    logic [7:0] want;
    host_read(2'd0, got);
    if (exp_q.size() == 0) chk({req, " queue empty"}, 1, 0);
    else begin
      want = exp_q.pop_front();
      chk(req, got, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] s, s0, d;
    logic ack;
    int m0;
    wq(5);
    rst_n = 1'b1;
    wq(2);
    host_read(2'd3, s);
    chk("R1 reset status", s, 8'h00);
    chk("R1 reset sda", sda_pull_low, 0);
    chk("R1 reset irq", irq, 0);

    host_write(2'd1, 8'h5A);
    bus_start();
    host_read(2'd3, s);
    chk("R1 start status", s, 8'h08);
    m0 = match_cnt;
    send_byte(8'hB4, ack);
    chk("R2 addr ack", ack, 1);
    chk("R2 match pulse", match_cnt, m0 + 1);
    host_read(2'd3, s);
    chk("R2 status after match", s, 8'h88);
    chk("R2 irq pin", irq, 1);
    host_write(2'd3, 8'h00);

    drive_data(8'h3C, 1'b1, ack);
    chk("R6 data ack", ack, 1);
    host_read(2'd3, s);
    chk("R6 status after byte", s, 8'h8D);
    drain("R6 byte value");
    host_read(2'd3, s);
    chk("R10 buf_full cleared", s, 8'h8C);
    host_write(2'd3, 8'h00);

    drive_data(8'h11, 1'b1, ack);
    chk("R6 second byte ack", ack, 1);
    drive_data(8'h22, 1'b0, ack);
    chk("R7 overflow nack", ack, 0);
    host_read(2'd3, s);
    chk("R7 overflow flag", s & 8'h41, 8'h41);
    drain("R7 old byte kept");

    host_read(2'd3, s0);
    host_write(2'd3, 8'hFF);
    host_read(2'd3, s);
    chk("R9 low bits unchanged", s & 8'h3F, s0 & 8'h3F);
    chk("R9 high bits written", s >> 6, 3);
    host_write(2'd3, 8'h00);
    host_read(2'd3, s);
    chk("R9 high bits cleared", s >> 6, 0);

    bus_stop();
    host_read(2'd3, s);
    chk("R1 stop status", s & 8'h18, 8'h10);
    chk("R1 stop releases sda", sda_pull_low, 0);

    m0 = match_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    chk("R3 wrong addr nack", ack, 0);
    send_byte(8'hB4, ack);
    chk("R3 ignored until start", ack, 0);
    chk("R3 no match", match_cnt, m0);
    bus_stop();

    bus_start();
    send_byte(8'h00, ack);
    chk("R5 gcall disabled nack", ack, 0);
    bus_stop();
    host_write(2'd2, 8'h02);
    host_write(2'd3, 8'h00);
    bus_start();
    send_byte(8'h00, ack);
    chk("R5 gcall enabled ack", ack, 1);
    host_read(2'd3, s);
    chk("R5 gcall status", s & 8'h22, 8'h20);
    drive_data(8'h77, 1'b1, ack);
    chk("R5 gcall data ack", ack, 1);
    drain("R5 gcall data");
    bus_stop();

    host_write(2'd2, 8'h10);
    host_write(2'd3, 8'h00);
    bus_start();
    chk("R1 start irq enabled", irq, 1);
    host_write(2'd3, 8'h00);
    bus_stop();
    chk("R1 stop irq enabled", irq, 1);

    host_write(2'd2, 8'h00);
    host_write(2'd3, 8'h00);
    host_write(2'd0, 8'hC3);
    bus_start();
    send_byte(8'hB5, ack);
    chk("R8 read addr ack", ack, 1);
    host_read(2'd3, s);
    chk("R8 read direction", s & 8'h02, 8'h02);
    recv_byte(1'b0, d);
    chk("R8 tx byte", d, 8'hC3);
    host_read(2'd3, s);
    chk("R8 tx done flags", s & 8'h81, 8'h80);
    recv_byte(1'b0, d);
    chk("R8 silent after nack", d, 8'hFF);
    bus_stop();

    host_write(2'd1, 8'hA7);
    host_write(2'd2, 8'h09);
    m0 = match_cnt;
    bus_start();
    send_byte(8'hF4, ack);
    chk("R4 first byte ack", ack, 1);
    chk("R4 no match after first", match_cnt, m0);
    send_byte(8'hA7, ack);
    chk("R4 second byte ack", ack, 1);
    chk("R4 match pulse", match_cnt, m0 + 1);
    drive_data(8'h5E, 1'b1, ack);
    chk("R4 data ack", ack, 1);
    drain("R4 data value");
    host_write(2'd0, 8'h96);
    bus_start();
    send_byte(8'hF5, ack);
    chk("R4 read after restart", ack, 1);
    recv_byte(1'b0, d);
    chk("R4 read byte", d, 8'h96);
    bus_stop();

    m0 = match_cnt;
    bus_start();
    send_byte(8'hF4, ack);
    send_byte(8'hA6, ack);
    chk("R4 wrong low nack", ack, 0);
    chk("R4 wrong low no match", match_cnt, m0);
    bus_stop();
    bus_start();
    send_byte(8'hF5, ack);
    chk("R4 read without match nack", ack, 0);
    bus_stop();

    wq(10);
    finish_run();
  end

endmodule